// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block sits beside a descriptor-processing engine and decides when the host should be told that work has finished. Each finished descriptor arrives as a one-cycle completion strobe, optionally tagged with an interrupt-on-done flag. The block keeps a count of completions that no message has yet covered. It raises one interrupt message when any of these happens: the count reaches a programmed threshold, a tagged completion arrives, or an optional idle timer expires. A message is a single-cycle strobe together with a data word and a 48-bit target address. Both values are captured from programmable registers in the cycle that the message is triggered.

The host can also retire completions it has already handled by polling, before any message was sent. It does this with a release strobe that carries a count. This lowers the uncovered count and, once the count reaches zero, stops the idle timer. A small write-only register port sets the count threshold, the timer enable, the timer limit, the message data word and the two halves of the address.

The control path is a three-state machine:
- ST_IDLE means no uncovered completions.
- ST_ACCUM means at least one completion is uncovered.
- ST_FIRE is the single cycle in which the strobe is driven.

The transitions are:
- IDLE to ACCUM on a completion.
- ACCUM to IDLE when a release retires every uncovered completion.
- Any state to FIRE when a trigger fires.
- FIRE to IDLE or to ACCUM, depending on whether completions arrived during the strobe.

Top module: `irq_coalescer`

## Requirements
- R1: After reset the block behaves as follows. No strobe is driven. The count threshold is 20, the timer limit is 176 and the timer is disabled. The message data word and address read as zero.
- R2: A write on the register port uses this address map; writes to addresses 5 to 7 change nothing.
  - Address 0: count threshold in cfg_wdata[14:0], timer enable in bit 18.
  - Address 1: timer limit in bits [12:0].
  - Address 2: message data word.
  - Address 3: address bits [31:0].
  - Address 4: address bits [47:32], taken from cfg_wdata[15:0].
- R3: The count trigger fires at the clock edge where the uncovered count, including a completion sampled at that edge, reaches a nonzero threshold. msg_valid is high in the following cycle and the count restarts from zero.
- R4: A threshold of zero disables the count trigger.
- R5: A completion with done_iod set makes msg_valid high in the very next cycle, whatever the count.
- R6: Let L be the timer limit, with a limit of 0 acting as 1. With the timer enabled and uncovered completions present, a message is triggered at the L-th consecutive clock edge without a completion after the last one. Every new completion restarts this idle span.
- R7: With the timer disabled, no message is raised without a completion.
- R8: A release lowers the uncovered count by rel_cnt, stopping at zero. A count of zero stops and clears the idle timer, so nothing fires later.
- R9: msg_valid lasts one cycle per trigger. msg_data and msg_addr hold the register values present at the triggering edge and keep them until the next trigger.
- R10: A completion sampled during the strobe cycle counts toward the next message. A tagged completion there produces a second strobe immediately after the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| done_valid | input | 1 | One descriptor completed this cycle |
| done_iod | input | 1 | The completing descriptor asks for notification |
| rel_valid | input | 1 | Host retires handled completions |
| rel_cnt | input | 15 | Number of completions retired |
| msg_valid | output | 1 | Single-cycle interrupt message request |
| msg_data | output | 32 | Message data word |
| msg_addr | output | 48 | Message target address |

## Verification
The bench attacks the exact edge at which each trigger fires:
- The 19th versus the 20th completion under the reset threshold. A comparison off by one would fire a cycle early or leave the count parked.
- Idle-timer expiry after a lone completion, and after completions spaced just under the limit. A timer that is not restarted by each completion would fire in the middle of the stream.
- A limit of zero, which must behave as a limit of one.

Release handling is probed by retiring more than the count and then waiting past the limit. A design that wraps the count, or leaves the timer running, would emit a stray message.

The strobe cycle itself is stressed with back-to-back tagged completions and with plain completions. A design that drops input while firing would lose a strobe or miscount the next group.

Payload capture is checked after the registers are rewritten without a trigger. It is also checked after writes to the unused addresses.

// File: rtl/coal_pkg.sv
package coal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_FIRE  = 2'd2
    } coal_state_t;

    localparam logic [2:0] REG_CTRL  = 3'd0;
    localparam logic [2:0] REG_LIMIT = 3'd1;
    localparam logic [2:0] REG_DATA  = 3'd2;
    localparam logic [2:0] REG_ALO   = 3'd3;
    localparam logic [2:0] REG_AHI   = 3'd4;
endpackage

// File: rtl/coal_regs.sv
module coal_regs #(
    parameter int REG_W    = 32,
    parameter int CNT_W    = 15,
    parameter int TMR_W    = 13,
    parameter int ADDR_W   = 48,
    parameter int TEN_BIT  = 18,
    parameter int RST_THR  = 20,
    parameter int RST_TLIM = 176
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [2:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [CNT_W-1:0]  thr,
    output logic              ten,
    output logic [TMR_W-1:0]  tlim,
    output logic [REG_W-1:0]  data,
    output logic [ADDR_W-1:0] maddr
);
    import coal_pkg::*;
    localparam int HI_W = ADDR_W - REG_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr   <= CNT_W'(RST_THR);
            ten   <= 1'b0;
            tlim  <= TMR_W'(RST_TLIM);
            data  <= '0;
            maddr <= '0;
        end else if (we) begin
            unique case (addr)
                REG_CTRL: begin
                    thr <= wdata[CNT_W-1:0];
                    ten <= wdata[TEN_BIT];
                end
                REG_LIMIT: tlim <= wdata[TMR_W-1:0];
                REG_DATA:  data <= wdata;
                REG_ALO:   maddr[REG_W-1:0] <= wdata;
                REG_AHI:   maddr[ADDR_W-1:REG_W] <= wdata[HI_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/coal_idle_timer.sv
module coal_idle_timer #(
    parameter int TMR_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [TMR_W-1:0] limit,
    output logic             expired
);
    logic [TMR_W-1:0] tmr_q;
    logic [TMR_W:0]   tmr_next;

    assign tmr_next = {1'b0, tmr_q} + {{TMR_W{1'b0}}, 1'b1};
    // Expiry: this edge completes the limit-th idle cycle (limit 0 acts as 1)
    assign expired  = tmr_next >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            tmr_q <= '0;
        else if (!tmr_next[TMR_W])
            tmr_q <= tmr_next[TMR_W-1:0];
    end
endmodule

// File: rtl/coal_ctrl.sv
module coal_ctrl #(
    parameter int CNT_W  = 15,
    parameter int REG_W  = 32,
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_valid,
    input  logic              done_iod,
    input  logic              rel_valid,
    input  logic [CNT_W-1:0]  rel_cnt,
    input  logic [CNT_W-1:0]  thr,
    input  logic              ten,
    input  logic              tmo_expired,
    input  logic [REG_W-1:0]  reg_data,
    input  logic [ADDR_W-1:0] reg_addr,
    output logic              tmr_clr,
    output logic              msg_valid,
    output logic [REG_W-1:0]  msg_data,
    output logic [ADDR_W-1:0] msg_addr
);
    import coal_pkg::*;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    coal_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_rel, cnt_add;
    logic             hit_iod, hit_cnt, hit_tmo, fire;

    always_comb begin
        if (rel_valid && rel_cnt >= cnt_q)
            cnt_rel = '0;
        else if (rel_valid)
            cnt_rel = cnt_q - rel_cnt;
        else
            cnt_rel = cnt_q;
        cnt_add = (done_valid && cnt_rel != CNT_MAX) ? cnt_rel + CNT_ONE : cnt_rel;
        hit_iod = done_valid && done_iod;
        hit_cnt = (thr != '0) && (cnt_add >= thr);
        hit_tmo = ten && tmo_expired && !done_valid && (cnt_rel != '0);
        fire    = hit_iod || hit_cnt || hit_tmo;
        tmr_clr = done_valid || fire || (cnt_rel == '0);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = fire ? ST_FIRE : (done_valid ? ST_ACCUM : ST_IDLE);
            ST_ACCUM: state_d = fire ? ST_FIRE : ((cnt_add == '0) ? ST_IDLE : ST_ACCUM);
            ST_FIRE:  state_d = fire ? ST_FIRE : ((cnt_add == '0) ? ST_IDLE : ST_ACCUM);
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and uncovered-completion count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= fire ? '0 : cnt_add;
        end
    end

    // outputs: payload captured on the triggering edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_data <= '0;
            msg_addr <= '0;
        end else if (fire) begin
            msg_data <= reg_data;
            msg_addr <= reg_addr;
        end
    end

    assign msg_valid = (state_q == ST_FIRE);
endmodule

// File: rtl/irq_coalescer.sv
module irq_coalescer #(
    parameter int REG_W    = 32,
    parameter int CNT_W    = 15,
    parameter int TMR_W    = 13,
    parameter int ADDR_W   = 48,
    parameter int TEN_BIT  = 18,
    parameter int RST_THR  = 20,
    parameter int RST_TLIM = 176
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              done_valid,
    input  logic              done_iod,
    input  logic              rel_valid,
    input  logic [CNT_W-1:0]  rel_cnt,
    output logic              msg_valid,
    output logic [REG_W-1:0]  msg_data,
    output logic [ADDR_W-1:0] msg_addr
);
    logic [CNT_W-1:0]  w_thr;
    logic              w_ten;
    logic [TMR_W-1:0]  w_tlim;
    logic [REG_W-1:0]  w_data;
    logic [ADDR_W-1:0] w_addr;
    logic              w_tmr_clr, w_expired;

    coal_regs #(
        .REG_W(REG_W), .CNT_W(CNT_W), .TMR_W(TMR_W), .ADDR_W(ADDR_W),
        .TEN_BIT(TEN_BIT), .RST_THR(RST_THR), .RST_TLIM(RST_TLIM)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .thr(w_thr), .ten(w_ten), .tlim(w_tlim), .data(w_data), .maddr(w_addr)
    );

    coal_idle_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(w_tmr_clr), .limit(w_tlim), .expired(w_expired)
    );

    coal_ctrl #(.CNT_W(CNT_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .done_valid(done_valid), .done_iod(done_iod),
        .rel_valid(rel_valid), .rel_cnt(rel_cnt),
        .thr(w_thr), .ten(w_ten), .tmo_expired(w_expired),
        .reg_data(w_data), .reg_addr(w_addr),
        .tmr_clr(w_tmr_clr),
        .msg_valid(msg_valid), .msg_data(msg_data), .msg_addr(msg_addr)
    );
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
    parameter int REG_W  = 32,
    parameter int CNT_W  = 15,
    parameter int ADDR_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              done_valid,
    input logic              done_iod,
    input logic              ten,
    input logic [CNT_W-1:0]  thr,
    input logic [REG_W-1:0]  reg_data,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              msg_valid,
    input logic [REG_W-1:0]  msg_data,
    input logic [ADDR_W-1:0] msg_addr
);
    a_r5_iod_next: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_iod) |=> msg_valid);

    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_valid && !cfg_we && !ten) |=> !msg_valid);

    a_r3_unit_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !cfg_we && thr == CNT_W'(1)) |=> msg_valid);

    a_r9_payload_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> (msg_data == $past(reg_data) && msg_addr == $past(reg_addr)));

    a_r9_payload_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid |-> ($stable(msg_data) && $stable(msg_addr)));
endmodule

bind irq_coalescer coal_checker #(.REG_W(REG_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .done_valid(done_valid), .done_iod(done_iod),
    .ten(w_ten), .thr(w_thr), .reg_data(w_data), .reg_addr(w_addr),
    .msg_valid(msg_valid), .msg_data(msg_data), .msg_addr(msg_addr)
);

// File: tb/tb_irq_coalescer.sv
module tb_irq_coalescer;
    localparam int PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        done_valid = 1'b0;
    logic        done_iod = 1'b0;
    logic        rel_valid = 1'b0;
    logic [14:0] rel_cnt = '0;
    logic        msg_valid;
    logic [31:0] msg_data;
    logic [47:0] msg_addr;

    irq_coalescer dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .done_valid(done_valid), .done_iod(done_iod), .rel_valid(rel_valid), .rel_cnt(rel_cnt),
        .msg_valid(msg_valid), .msg_data(msg_data), .msg_addr(msg_addr)
    );

    always #(PER/2) clk = ~clk;

    int n_cmp = 0, n_bad = 0, strobes = 0;
    string cur_req = "R1";

    // behavioural reference state
    int          m_cnt, m_tmr, m_thr, m_lim;
    bit          m_en, e_v;
    logic [31:0] m_data, e_data;
    logic [47:0] m_addr, e_addr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_tmr = 0; m_thr = 20; m_lim = 176; m_en = 0;
            m_data = '0; m_addr = '0; e_v = 0; e_data = '0; e_addr = '0;
        end else begin
            int  c, nc;
            bit  f, idle;
            c = (rel_valid && int'(rel_cnt) >= m_cnt) ? 0 : m_cnt - (rel_valid ? int'(rel_cnt) : 0);
            nc = (done_valid && c < 32767) ? c + 1 : c;
            idle = (m_tmr + 1) >= m_lim;
            f = (done_valid && done_iod) || (m_thr != 0 && nc >= m_thr)
                || (m_en && idle && !done_valid && c != 0);
            if (done_valid || f || c == 0) m_tmr = 0;
            else if (m_tmr < 8191) m_tmr = m_tmr + 1;
            m_cnt = f ? 0 : nc;
            e_v = f;
            if (f) begin e_data = m_data; e_addr = m_addr; end
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: begin m_thr = int'(cfg_wdata[14:0]); m_en = cfg_wdata[18]; end
                    3'd1: m_lim = int'(cfg_wdata[12:0]);
                    3'd2: m_data = cfg_wdata;
                    3'd3: m_addr[31:0] = cfg_wdata;
                    3'd4: m_addr[47:32] = cfg_wdata[15:0];
                    default: ;
                endcase
            end
        end
        #2;
        n_cmp++;
        if (msg_valid !== e_v || (e_v && (msg_data !== e_data || msg_addr !== e_addr))) begin
            n_bad++;
            $display("FAIL %s: valid=%0b data=%h addr=%h expected valid=%0b data=%h addr=%h",
                     cur_req, msg_valid, msg_data, msg_addr, e_v, e_data, e_addr);
        end
        if (msg_valid === 1'b1) strobes++;
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic done1(input bit iod);
        done_valid = 1'b1; done_iod = iod;
        @(negedge clk);
        done_valid = 1'b0; done_iod = 1'b0;
    endtask

    task automatic release_n(input int n);
        rel_valid = 1'b1; rel_cnt = 15'(n);
        @(negedge clk);
        rel_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_strobes(input int mark, input int exp, input string req);
        n_cmp++;
        if (strobes - mark != exp) begin
            n_bad++;
            $display("FAIL %s: strobes=%0d expected=%0d", req, strobes - mark, exp);
        end
    endtask

    task automatic expect_payload(input logic [31:0] d, input logic [47:0] a, input string req);
        n_cmp++;
        if (msg_data !== d || msg_addr !== a) begin
            n_bad++;
            $display("FAIL %s: data=%h addr=%h expected data=%h addr=%h", req, msg_data, msg_addr, d, a);
        end
    endtask

    initial begin
        #(PER * 150000);
        n_bad++;
        $display("FAIL watchdog: run actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int mk;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cur_req = "R1"; mk = strobes;
        idle(5);
        expect_strobes(mk, 0, "R1");
        expect_payload(32'h0, 48'h0, "R1");

        // R3 with reset threshold 20: 19 completions stay silent, the 20th fires
        cur_req = "R3"; mk = strobes;
        repeat (19) done1(1'b0);
        idle(10);
        expect_strobes(mk, 0, "R3");
        done1(1'b0);
        idle(3);
        expect_strobes(mk, 1, "R3");

        // R5: tagged completion fires next cycle
        cur_req = "R5"; mk = strobes;
        done1(1'b1);
        idle(3);
        expect_strobes(mk, 1, "R5");

        // R7: timer disabled, nothing fires while waiting past the limit
        cur_req = "R7"; mk = strobes;
        repeat (3) done1(1'b0);
        idle(400);
        expect_strobes(mk, 0, "R7");
        // R8: release more than outstanding saturates at zero
        cur_req = "R8";
        release_n(10);
        idle(3);

        // R2 and R6: enable timer, limit 5
        cur_req = "R6"; mk = strobes;
        wr(3'd0, 32'h0004_0014);
        wr(3'd1, 32'd5);
        done1(1'b0);
        idle(10);
        expect_strobes(mk, 1, "R6");
        // R6: completions spaced below the limit keep restarting the timer
        mk = strobes;
        for (int i = 0; i < 5; i++) begin
            done1(1'b0);
            idle(3);
        end
        expect_strobes(mk, 0, "R6");
        idle(10);
        expect_strobes(mk, 1, "R6");

        // R8: full release stops the timer
        cur_req = "R8"; mk = strobes;
        repeat (3) done1(1'b0);
        release_n(3);
        idle(20);
        expect_strobes(mk, 0, "R8");
        repeat (2) done1(1'b0);
        release_n(1);
        idle(10);
        expect_strobes(mk, 1, "R8");

        // R4: threshold zero, timer off
        cur_req = "R4"; mk = strobes;
        wr(3'd0, 32'h0);
        repeat (40) done1(1'b0);
        idle(20);
        expect_strobes(mk, 0, "R4");
        done1(1'b1);
        idle(3);
        expect_strobes(mk, 1, "R4");

        // R9 and R2: payload capture, upper address truncation, unused addresses
        cur_req = "R9"; mk = strobes;
        wr(3'd2, 32'hA5A5_1234);
        wr(3'd3, 32'h1357_9BDF);
        wr(3'd4, 32'hFFFF_BEEF);
        wr(3'd5, 32'hDEAD_0000);
        wr(3'd7, 32'h0000_0000);
        wr(3'd0, 32'h0000_0001);
        done1(1'b0);
        expect_payload(32'hA5A5_1234, 48'hBEEF_1357_9BDF, "R9");
        wr(3'd2, 32'h0BAD_0BAD);
        idle(5);
        expect_strobes(mk, 1, "R9");
        expect_payload(32'hA5A5_1234, 48'hBEEF_1357_9BDF, "R9");
        cur_req = "R2"; mk = strobes;
        done1(1'b0);
        expect_payload(32'h0BAD_0BAD, 48'hBEEF_1357_9BDF, "R2");
        idle(3);
        expect_strobes(mk, 1, "R2");

        // R10: completions during strobe cycle
        cur_req = "R10"; mk = strobes;
        wr(3'd0, 32'h0000_0002);
        done1(1'b1);
        done1(1'b1);
        idle(4);
        expect_strobes(mk, 2, "R10");
        mk = strobes;
        done1(1'b1);
        done1(1'b0);
        done1(1'b0);
        idle(4);
        expect_strobes(mk, 2, "R10");

        // R6: limit zero acts as one
        cur_req = "R6"; mk = strobes;
        wr(3'd0, 32'h0004_0014);
        wr(3'd1, 32'd0);
        done1(1'b0);
        idle(4);
        expect_strobes(mk, 1, "R6");

        idle(3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule